// File: doc/BRIEF.md
# Dual-Rate Decimal-Step PWM Generator

This block drives two slow pulse-width-modulated outputs from one shared periodic tick of about 90 us. Each channel divides the tick by its own fixed reload constant to form a step. With the defaults, a step is 37 ticks for the slower channel and 16 ticks for the faster one. Ten steps make one output period, so the outputs run at roughly 30.03 Hz and 69.44 Hz. Duty is chosen per channel as a whole number of tenths, from 0 to 10.

The tick comes either from the `tick_in` port or from an internal divider of the system clock. A parameter selects the source. Each channel keeps a shadow copy of its duty input. The shadow is refreshed only when the channel's ten-step phase counter wraps, so a duty written mid-period never distorts the current period.

Each channel is sequenced by a small state machine with three states. CH_INIT captures the duty and loads the counters. It is left unconditionally for CH_IDLE on the first clock after reset. CH_IDLE waits for a step pulse from the prescaler and moves to CH_ADV when one arrives. CH_ADV decrements the phase, updates the output, and on wrap reloads the phase and the shadow duty. It always returns to CH_IDLE.

Top module: `pwm_dual_decstep`

## Requirements
- R1: While reset is asserted, and after its release until the first step, both outputs are low.
- R2: Channel A steps once every RELOAD_A ticks (default 37) and channel B once every RELOAD_B ticks (default 16). A tick that does not complete a prescaler count leaves the phase unchanged.
- R3: On each step the phase value goes 9, 8, …, 0. After a step the output is high exactly when the new phase value is below the channel's active duty. The high part of a period is therefore its last `duty` steps.
- R4: One output period is exactly ten steps. The phase sequence then restarts at 9.
- R5: An output changes only as the result of a step. Ticks that do not complete a step leave both outputs as they were.
- R6: A duty of 0 keeps the output low for whole periods. A duty of 10 keeps it high for whole periods.
- R7: A duty input above 10 (values 11 to 15 on the 4-bit port) acts as 10, i.e. 100 %.
- R8: The active duty is loaded from the duty input only on the step that wraps the phase to its restart value. A change at any other time takes effect from the next period.
- R9: The two channels run independently. Each output follows only its own duty input and prescaler.
- R10: With TICK_INTERNAL=1, a tick is produced every TICK_DIV clocks and `tick_in` is ignored. The output period is then 10·RELOAD·TICK_DIV clocks and the high time is duty·RELOAD·TICK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | External base-tick strobe, one clock wide (unused when TICK_INTERNAL=1) |
| duty_a | input | DUTY_W | Duty in tenths for channel A |
| duty_b | input | DUTY_W | Duty in tenths for channel B |
| pwm_a | output | 1 | Channel A PWM output (about 30 Hz by default) |
| pwm_b | output | 1 | Channel B PWM output (about 70 Hz by default) |

## Verification
The hardest case to reach from the ports is a duty change that lands strictly inside a period. To test it, the stimulus must count ticks so that the write falls between phase wraps, and must then watch both the rest of that period and the next one. The bench handles this by driving each tick itself and carrying its own tick-level model of both prescalers and phase counters. The mid-period write in R8 can then be placed a known number of steps after a wrap. The bench also compares both outputs after every tick, which catches any change that is not tied to a step.

// File: rtl/pwm_decstep_pkg.sv
package pwm_decstep_pkg;

    // Per-channel sequencing states
    typedef enum logic [1:0] {
        CH_INIT = 2'd0,   // capture duty, load counters
        CH_IDLE = 2'd1,   // wait for a prescaler step
        CH_ADV  = 2'd2    // advance phase, update output
    } ch_state_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/pwm_tick_source.sv
module pwm_tick_source #(
    parameter bit TICK_INTERNAL = 1'b0,
    parameter int TICK_DIV      = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ext,
    output logic tick_o
);

    generate
        if (TICK_INTERNAL) begin : g_internal
            localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
            logic [DW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q  <= '0;
                    tick_o <= 1'b0;
                end else if (div_q == DW'(TICK_DIV - 1)) begin
                    div_q  <= '0;
                    tick_o <= 1'b1;
                end else begin
                    div_q  <= div_q + 1'b1;
                    tick_o <= 1'b0;
                end
            end

            AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                int'(div_q) < TICK_DIV); // R10
        end else begin : g_external
            always_ff @(posedge clk) begin
                if (!rst_n) tick_o <= 1'b0;
                else        tick_o <= tick_ext;
            end
        end
    endgenerate

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int RELOAD = 37
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic step_o
);

    localparam int CW = $clog2(RELOAD + 1);

    logic [CW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= CW'(RELOAD);
            step_o <= 1'b0;
        end else if (tick_i) begin
            if (pre_q == CW'(1)) begin
                pre_q  <= CW'(RELOAD);
                step_o <= 1'b1;
            end else begin
                pre_q  <= pre_q - 1'b1;
                step_o <= 1'b0;
            end
        end else begin
            step_o <= 1'b0;
        end
    end

    initial begin
        AST_RELOAD_MIN: assert (RELOAD >= 2); // R2
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q != '0) && (int'(pre_q) <= RELOAD)); // R2

    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> $past(tick_i)); // R2

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o); // R2

endmodule

// File: rtl/pwm_phase_channel.sv
module pwm_phase_channel
    import pwm_decstep_pkg::*;
#(
    parameter int STEPS  = 10,
    parameter int DUTY_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);

    localparam int PW = $clog2(STEPS + 1);

    ch_state_t     state_q, state_d;
    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_dec;
    logic [PW-1:0] shadow_q;
    logic [PW-1:0] duty_cl;

    // Saturate the requested duty at a full period
    always_comb begin
        if (int'(duty_i) > STEPS) duty_cl = PW'(STEPS);
        else                      duty_cl = PW'(duty_i);
    end

    assign phase_dec = phase_q - 1'b1;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_INIT;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_INIT: state_d = CH_IDLE;
            CH_IDLE: if (step_i) state_d = CH_ADV;
            CH_ADV:  state_d = CH_IDLE;
            default: state_d = CH_INIT;
        endcase
    end

    // Datapath and output, driven by the current state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PW'(STEPS);
            shadow_q <= '0;
            pwm_o    <= 1'b0;
        end else begin
            unique case (state_q)
                CH_INIT: begin
                    phase_q  <= PW'(STEPS);
                    shadow_q <= duty_cl;
                    pwm_o    <= 1'b0;
                end
                CH_ADV: begin
                    pwm_o <= (phase_dec < shadow_q);
                    if (phase_dec == '0) begin
                        phase_q  <= PW'(STEPS);
                        shadow_q <= duty_cl;
                    end else begin
                        phase_q  <= phase_dec;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != '0) && (int'(phase_q) <= STEPS)); // R4

    AST_SHADOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(shadow_q) <= STEPS); // R7

    AST_OUT_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_ADV) |=> $stable(pwm_o)); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE) |=> $stable(shadow_q)); // R8

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ADV && shadow_q == '0) |=> !pwm_o); // R6

    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ADV && shadow_q == PW'(STEPS)) |=> pwm_o); // R6

    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ADV && phase_q == PW'(1)) |=> (phase_q == PW'(STEPS))); // R4

endmodule

// File: rtl/pwm_dual_decstep.sv
module pwm_dual_decstep
    import pwm_decstep_pkg::*;
#(
    parameter bit TICK_INTERNAL = 1'b0,
    parameter int TICK_DIV      = 4500,
    parameter int RELOAD_A      = 37,
    parameter int RELOAD_B      = 16,
    parameter int STEPS         = 10,
    parameter int DUTY_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    output logic              pwm_a,
    output logic              pwm_b
);

    logic                            tick;
    logic [NUM_CH-1:0][DUTY_W-1:0]   duty_v;
    logic [NUM_CH-1:0]               step_v;
    logic [NUM_CH-1:0]               pwm_v;

    assign duty_v[0] = duty_a;
    assign duty_v[1] = duty_b;
    assign pwm_a     = pwm_v[0];
    assign pwm_b     = pwm_v[1];

    pwm_tick_source #(
        .TICK_INTERNAL (TICK_INTERNAL),
        .TICK_DIV      (TICK_DIV)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ext (tick_in),
        .tick_o   (tick)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            localparam int RL = (g == 0) ? RELOAD_A : RELOAD_B;

            pwm_prescaler #(
                .RELOAD (RL)
            ) u_pre (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick_i (tick),
                .step_o (step_v[g])
            );

            pwm_phase_channel #(
                .STEPS  (STEPS),
                .DUTY_W (DUTY_W)
            ) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .step_i (step_v[g]),
                .duty_i (duty_v[g]),
                .pwm_o  (pwm_v[g])
            );
        end
    endgenerate

endmodule

// File: tb/pwm_dual_decstep_tb_top.sv
`timescale 1ns/1ps
module pwm_dual_decstep_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic [3:0] duty_a = 4'd0;
    logic [3:0] duty_b = 4'd0;
    logic       pwm_a, pwm_b;
    logic       pwm_ia, pwm_ib;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_dual_decstep dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .duty_a(duty_a), .duty_b(duty_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // Internal-tick variant: tick_in is toggled by the main tests and must be ignored
    pwm_dual_decstep #(.TICK_INTERNAL(1'b1), .TICK_DIV(5), .RELOAD_A(2), .RELOAD_B(3)) dut_int (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .duty_a(4'd5), .duty_b(4'd3), .pwm_a(pwm_ia), .pwm_b(pwm_ib)
    );

    // Tick-level reference model
    int rel [2] = '{37, 16};
    int pre_m [2];
    int ph_m  [2];
    int sh_m  [2];
    bit out_m [2];
    bit stp_m [2];

    function automatic int clampd(int d);
        return (d > 10) ? 10 : d;
    endfunction

    function automatic int duty_of(int c);
        return (c == 0) ? int'(duty_a) : int'(duty_b);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            pre_m[c] = rel[c];
            ph_m[c]  = 10;
            sh_m[c]  = clampd(duty_of(c));
            out_m[c] = 1'b0;
        end
    endtask

    task automatic model_tick();
        for (int c = 0; c < 2; c++) begin
            stp_m[c] = 1'b0;
            if (pre_m[c] == 1) begin
                pre_m[c] = rel[c];
                stp_m[c] = 1'b1;
                ph_m[c]  = ph_m[c] - 1;
                out_m[c] = (ph_m[c] < sh_m[c]);
                if (ph_m[c] == 0) begin
                    ph_m[c] = 10;
                    sh_m[c] = clampd(duty_of(c));
                end
            end else begin
                pre_m[c] = pre_m[c] - 1;
            end
        end
    endtask

    // One tick, then compare both outputs once the step has fully propagated
    task automatic tick_once(string tag);
        @(negedge clk) tick_in = 1'b1;
        @(negedge clk) tick_in = 1'b0;
        repeat (3) @(negedge clk);
        model_tick();
        chk(stp_m[0] ? {tag, " chA"} : "R5 chA hold", int'(pwm_a), int'(out_m[0]));
        chk(stp_m[1] ? {tag, " chB"} : "R5 chB hold", int'(pwm_b), int'(out_m[1]));
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) tick_once(tag);
    endtask

    task automatic do_reset(logic [3:0] da, logic [3:0] db);
        @(negedge clk);
        rst_n  = 1'b0;
        duty_a = da;
        duty_b = db;
        repeat (3) @(negedge clk);
        chk("R1 reset A", int'(pwm_a), 0);
        chk("R1 reset B", int'(pwm_b), 0);
        rst_n = 1'b1;
        model_reset();
        repeat (2) @(negedge clk);
        chk("R1 post-reset A", int'(pwm_a), 0);
        chk("R1 post-reset B", int'(pwm_b), 0);
    endtask

    // Count, over one channel-A period aligned to a wrap, how many steps are high
    task automatic count_high_a(string tag, int exp_high);
        int hi;
        hi = 0;
        for (int s = 0; s < 10; s++) begin
            ticks(37, tag);
            hi += int'(pwm_a);
        end
        chk({tag, " high steps A"}, hi, exp_high);
    endtask

    task automatic t_reset();
        do_reset(4'd5, 4'd1);
        ticks(36, "R2");
        chk("R2 no step before 37 ticks", int'(pwm_a), 0);
    endtask

    task automatic t_basic();
        do_reset(4'd5, 4'd1);
        count_high_a("R2 R3 R4", 5);
        count_high_a("R3 R4", 5);
    endtask

    task automatic t_extremes();
        do_reset(4'd0, 4'd10);
        count_high_a("R6 zero", 0);
        chk("R6 full B", int'(pwm_b), 1);
    endtask

    task automatic t_clamp();
        do_reset(4'd15, 4'd12);
        count_high_a("R7 clamp", 10);
        chk("R7 clamp B", int'(pwm_b), 1);
    endtask

    task automatic t_midperiod();
        do_reset(4'd2, 4'd4);
        ticks(37 * 3, "R8 before");
        duty_a = 4'd8;
        // Remainder of the first period keeps duty 2
        begin
            int hi;
            hi = 0;
            for (int s = 3; s < 10; s++) begin
                ticks(37, "R8 same period");
                hi += int'(pwm_a);
            end
            chk("R8 old duty kept", hi, 2);
        end
        count_high_a("R8 next period", 8);
    endtask

    task automatic t_independent();
        do_reset(4'd3, 4'd7);
        ticks(37 * 10, "R9");
        duty_b = 4'd1;
        ticks(37 * 10, "R9 B change");
    endtask

    task automatic t_internal();
        int t0, t1, t2;
        @(posedge pwm_ia) t0 = cyc;
        @(negedge pwm_ia) t1 = cyc;
        @(posedge pwm_ia) t2 = cyc;
        chk("R10 period A", t2 - t0, 100);
        chk("R10 high A", t1 - t0, 50);
        @(posedge pwm_ib) t0 = cyc;
        @(negedge pwm_ib) t1 = cyc;
        @(posedge pwm_ib) t2 = cyc;
        chk("R10 period B", t2 - t0, 150);
        chk("R10 high B", t1 - t0, 45);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_extremes();
        t_clamp();
        t_midperiod();
        t_independent();
        t_internal();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule